// File: doc/BRIEF.md
# Packed SIMD Halving Add/Subtract Unit

This block is a one-stage vector datapath that combines two 128-bit operand vectors element by element. For each pair of elements it forms either the sum or the difference (first operand minus second) at one bit more than the element width, so that no carry or borrow is lost. It then drops the lowest bit of that wide result and writes back the remaining bits at the original element width. No rounding constant is added, so the result always rounds toward minus infinity.

Each operation is described by a small set of control inputs. A subtract flag picks between add and subtract. An unsigned flag picks how the extra top bit is filled. A 2-bit size code sets the element width to 8, 16 or 32 bits. A quad flag chooses between a 128-bit and a 64-bit active vector. Every element in one operation has the same width and signedness. The block accepts one operation per clock on a valid strobe and registers the result. Size code 3 is rejected and reported on a dedicated flag.

Top module: `simd_halving_unit`

## Requirements
- R1: With `op_sub`=0, every result element equals (a + b) computed at element width + 1 bits, shifted right by one, keeping the low element-width bits.
- R2: With `op_sub`=1, every result element equals (a − b) computed at element width + 1 bits with `opnd_a` as minuend, shifted right by one, keeping the low element-width bits.
- R3: With `is_unsigned`=0 the extra top bit of each element is a copy of its sign bit. With `is_unsigned`=1 it is zero. For example, 8-bit 0x80 + 0x00 gives 0xC0 when signed and 0x40 when unsigned.
- R4: `elem_size` code 0 selects 8-bit elements, 1 selects 16-bit and 2 selects 32-bit. Element i occupies bits [i*W +: W], and no carry or borrow crosses an element boundary.
- R5: With `quad`=1 all 128 bits are processed. With `quad`=0 only bits [63:0] are processed and bits [127:64] of the result are written as zero.
- R6: An accepted operation with `elem_size`=3 raises `undef_op` for one cycle, exactly one clock after the strobe. `out_valid` stays low in that cycle and `result` keeps its previous value.
- R7: `out_valid` is high exactly one clock after an accepted legal strobe and low otherwise. `result` changes only on an accepted legal operation.
- R8: A synchronous active-low reset clears `out_valid`, `undef_op` and `result` to zero.
- R9: The shift truncates. Unsigned 8-bit 0xFF + 0xFF gives 0xFF. Signed 8-bit 0x80 − 0x7F gives 0x80. Unsigned 8-bit 0x00 − 0x01 gives 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe: accept the operation on this edge |
| op_sub | input | 1 | 0 = halving add, 1 = halving subtract |
| is_unsigned | input | 1 | 1 = unsigned elements, 0 = signed |
| elem_size | input | 2 | Element width code: 0 = 8, 1 = 16, 2 = 32, 3 = illegal |
| quad | input | 1 | 1 = 128-bit vector, 0 = low 64 bits only |
| opnd_a | input | 128 | First operand (minuend) |
| opnd_b | input | 128 | Second operand |
| out_valid | output | 1 | Result valid, one clock after a legal strobe |
| result | output | 128 | Registered halved result |
| undef_op | output | 1 | Illegal size code seen on the previous strobe |

## Verification
The hardest situation to reach from the ports is an illegal size code arriving after a result register that already holds a known non-zero value. Only then can a clobbered or cleared register be told apart from a correctly held one. The bench first runs a legal operation whose result is distinctive, then sends size code 3 with fresh operands. It checks that the old value stays in place while `undef_op` rises. Lane isolation is exercised with operands whose 8-bit sub-lanes would carry differently than a true 16-bit or 32-bit element.

// File: rtl/simd_halving_pkg.sv
// Package: shared size codes and vector constants for the halving unit.
// Assumes a vector width that is a multiple of 64 bits.
package simd_halving_pkg;
    typedef enum logic [1:0] {
        SZ_B8  = 2'd0,
        SZ_B16 = 2'd1,
        SZ_B32 = 2'd2,
        SZ_BAD = 2'd3
    } elem_size_e;

    localparam int unsigned VEC_W_DEF = 128;
endpackage

// File: rtl/halving_lane.sv
// Module: one element of a halving add/subtract.
// Computes (a +/- b) at W+1 bits, filling the guard bit from the sign
// bit (signed) or with zero (unsigned), then drops the low bit.
// Assumes: purely combinational; W >= 2.
module halving_lane #(
    parameter int unsigned W = 8
) (
    input  logic         sub,
    input  logic         sgn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    logic [W:0] a_ext;
    logic [W:0] b_ext;
    logic [W:0] wide;

    // Extend both operands by one guard bit according to signedness.
    always_comb begin
        a_ext = {sgn & a[W-1], a};
        b_ext = {sgn & b[W-1], b};
    end

    // Full-precision sum or difference, then truncating halve.
    always_comb begin
        wide = sub ? (a_ext - b_ext) : (a_ext + b_ext);
        y    = W'(wide >> 1);
    end

    // The halved sum of two values lies between them (R1).
    always_comb begin
        if (!sub) begin
            if (sgn) begin
                assert_mean_between_s_R1: assert (
                    ($signed(y) >= (($signed(a) < $signed(b)) ? $signed(a) : $signed(b))) &&
                    ($signed(y) <= (($signed(a) > $signed(b)) ? $signed(a) : $signed(b))));
            end else begin
                assert_mean_between_u_R1: assert (
                    (y >= ((a < b) ? a : b)) && (y <= ((a > b) ? a : b)));
            end
        end
    end
endmodule

// File: rtl/lane_array.sv
// Module: a row of identical halving lanes covering the whole vector at
// one element width.
// Assumes DATA_W is a multiple of ELEM_W.
module lane_array #(
    parameter int unsigned DATA_W = 128,
    parameter int unsigned ELEM_W = 8
) (
    input  logic              sub,
    input  logic              sgn,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    localparam int unsigned LANES = DATA_W / ELEM_W;

    // One lane per element slot; lanes share only the control bits.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        halving_lane #(.W(ELEM_W)) u_lane (
            .sub (sub),
            .sgn (sgn),
            .a   (a[i*ELEM_W +: ELEM_W]),
            .b   (b[i*ELEM_W +: ELEM_W]),
            .y   (y[i*ELEM_W +: ELEM_W])
        );
    end
endmodule

// File: rtl/simd_halving_unit.sv
// Module: packed SIMD halving add/subtract, one register stage.
// Three lane arrays (8/16/32-bit) run in parallel. The size code picks
// one of them, and the quad flag zeroes the upper half for 64-bit vectors.
// The result and flags are registered on the valid strobe. Size code 3 is
// reported on undef_op and leaves the result register untouched.
// Assumes: synchronous active-low reset; VEC_W a multiple of 64.
module simd_halving_unit
    import simd_halving_pkg::*;
#(
    parameter int unsigned VEC_W = VEC_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             op_sub,
    input  logic             is_unsigned,
    input  logic [1:0]       elem_size,
    input  logic             quad,
    input  logic [VEC_W-1:0] opnd_a,
    input  logic [VEC_W-1:0] opnd_b,
    output logic             out_valid,
    output logic [VEC_W-1:0] result,
    output logic             undef_op
);
    localparam int unsigned HALF_W = VEC_W / 2;

    logic             sgn;
    logic             legal;
    logic [VEC_W-1:0] y8;
    logic [VEC_W-1:0] y16;
    logic [VEC_W-1:0] y32;
    logic [VEC_W-1:0] picked;
    logic [VEC_W-1:0] masked;

    assign sgn   = ~is_unsigned;
    assign legal = (elem_size_e'(elem_size) != SZ_BAD);

    lane_array #(.DATA_W(VEC_W), .ELEM_W(8)) u_arr8 (
        .sub(op_sub), .sgn(sgn), .a(opnd_a), .b(opnd_b), .y(y8)
    );
    lane_array #(.DATA_W(VEC_W), .ELEM_W(16)) u_arr16 (
        .sub(op_sub), .sgn(sgn), .a(opnd_a), .b(opnd_b), .y(y16)
    );
    lane_array #(.DATA_W(VEC_W), .ELEM_W(32)) u_arr32 (
        .sub(op_sub), .sgn(sgn), .a(opnd_a), .b(opnd_b), .y(y32)
    );

    // Choose the lane array matching the element width code.
    always_comb begin
        unique case (elem_size_e'(elem_size))
            SZ_B8:   picked = y8;
            SZ_B16:  picked = y16;
            SZ_B32:  picked = y32;
            default: picked = result;
        endcase
    end

    // Zero the upper half when only a 64-bit vector is active.
    always_comb begin
        masked = picked;
        if (!quad) begin
            masked[VEC_W-1:HALF_W] = '0;
        end
    end

    // Output register: capture legal results, flag illegal size codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            undef_op  <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid & legal;
            undef_op  <= in_valid & ~legal;
            if (in_valid && legal) begin
                result <= masked;
            end
        end
    end

    // A legal strobe yields out_valid on the next clock (R7).
    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && legal) |=> out_valid);

    // Without a legal strobe the result register holds (R7).
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && legal) |=> $stable(result));

    // An illegal size code raises undef_op and never out_valid (R6).
    assert_undef_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && elem_size == 2'd3) |=> (undef_op && !out_valid));

    // Valid and illegal flags are never high together (R6).
    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(undef_op && out_valid));

    // A 64-bit operation writes zeros into the upper half (R5).
    assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && legal && !quad) |=> (result[VEC_W-1:HALF_W] == '0));
endmodule

// File: tb/test_simd_halving_unit.sv
module test_simd_halving_unit;
    localparam int VW = 128;

    typedef struct packed {
        logic          sub;
        logic          uns;
        logic [1:0]    sz;
        logic          qd;
        logic [VW-1:0] a;
        logic [VW-1:0] b;
        logic [VW-1:0] e;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TABLE [NV] = '{
        '{1'b0, 1'b1, 2'd0, 1'b1, {16{8'hFF}}, {16{8'hFF}}, {16{8'hFF}}},
        '{1'b1, 1'b0, 2'd0, 1'b1, {16{8'h80}}, {16{8'h7F}}, {16{8'h80}}},
        '{1'b1, 1'b1, 2'd0, 1'b1, {16{8'h00}}, {16{8'h01}}, {16{8'hFF}}},
        '{1'b0, 1'b0, 2'd0, 1'b1, {16{8'h80}}, {16{8'h00}}, {16{8'hC0}}},
        '{1'b0, 1'b1, 2'd0, 1'b1, {16{8'h80}}, {16{8'h00}}, {16{8'h40}}},
        '{1'b0, 1'b1, 2'd1, 1'b1, {8{16'hFFFF}}, {8{16'h0001}}, {8{16'h8000}}},
        '{1'b0, 1'b1, 2'd2, 1'b1, {4{32'hFFFFFFFF}}, {4{32'h00000001}}, {4{32'h80000000}}},
        '{1'b1, 1'b0, 2'd1, 1'b1, {8{16'h0001}}, {8{16'h0004}}, {8{16'hFFFE}}},
        '{1'b1, 1'b0, 2'd2, 1'b1, {4{32'h0}}, {4{32'h3}}, {4{32'hFFFFFFFE}}},
        '{1'b0, 1'b1, 2'd0, 1'b0, {16{8'h10}}, {16{8'h20}}, {64'h0, {8{8'h18}}}},
        '{1'b1, 1'b1, 2'd2, 1'b0, {4{32'hA}}, {4{32'h4}}, {64'h0, {2{32'h3}}}},
        '{1'b0, 1'b0, 2'd2, 1'b1, {4{32'h7FFFFFFF}}, {4{32'h7FFFFFFF}}, {4{32'h7FFFFFFF}}}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          op_sub = 1'b0;
    logic          is_unsigned = 1'b0;
    logic [1:0]    elem_size = 2'd0;
    logic          quad = 1'b1;
    logic [VW-1:0] opnd_a = '0;
    logic [VW-1:0] opnd_b = '0;
    logic          out_valid;
    logic [VW-1:0] result;
    logic          undef_op;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    simd_halving_unit i_simd_halving_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
        .is_unsigned(is_unsigned), .elem_size(elem_size), .quad(quad),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid),
        .result(result), .undef_op(undef_op)
    );

    function automatic string tag_of(int i);
        case (i)
            0, 1, 2: return "R9";
            3, 4:    return "R3";
            5, 6:    return "R4";
            7, 8:    return "R2";
            9, 10:   return "R5";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one operation for a single cycle; return at the next negedge,
    // when the registered outputs reflect it.
    task automatic issue(logic s, logic u, logic [1:0] z, logic q,
                         logic [VW-1:0] a, logic [VW-1:0] b);
        @(negedge clk);
        op_sub = s; is_unsigned = u; elem_size = z; quad = q;
        opnd_a = a; opnd_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [VW-1:0] held;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8", {127'b0, out_valid}, '0);
        chk("R8", {127'b0, undef_op}, '0);
        chk("R8", result, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            issue(TABLE[i].sub, TABLE[i].uns, TABLE[i].sz, TABLE[i].qd,
                  TABLE[i].a, TABLE[i].b);
            chk(tag_of(i), result, TABLE[i].e);
            chk("R7", {127'b0, out_valid}, 128'd1);
        end

        // R7: one cycle later out_valid drops and result holds
        held = result;
        @(negedge clk);
        chk("R7", {127'b0, out_valid}, '0);
        chk("R7", result, held);

        // R4: mixed lanes at 16 bits, low byte carry must reach high byte
        issue(1'b0, 1'b1, 2'd1, 1'b1, {8{16'h00FF}}, {8{16'h0001}});
        chk("R4", result, {8{16'h0080}});
        held = result;

        // R6: illegal size keeps the distinctive result
        issue(1'b0, 1'b1, 2'd3, 1'b1, {16{8'h11}}, {16{8'h22}});
        chk("R6", {127'b0, undef_op}, 128'd1);
        chk("R6", {127'b0, out_valid}, '0);
        chk("R6", result, held);
        @(negedge clk);
        chk("R6", {127'b0, undef_op}, '0);

        // R8: synchronous reset during a strobe clears everything
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1; elem_size = 2'd0;
        @(negedge clk);
        chk("R8", {127'b0, out_valid}, '0);
        chk("R8", result, '0);
        in_valid = 1'b0; rst_n = 1'b1;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule